// File: doc/BRIEF.md
# SPI Receive Queue with Watermark Flag

This block sits between the receive shifter of an SPI port and the bus-side data registers. When queue mode is enabled, every word finished by the shifter arrives as a one-cycle valid pulse with its data. The block stores it in an eight-byte queue. The bus later takes the oldest word out through two byte-wide read strobes: one for the high data register and one for the low data register.

The data width is chosen by a mode input. In 8-bit mode each received word costs one byte of storage, and reading the low register takes it out of the queue. In 16-bit mode each word costs two bytes. The high byte is read first, and the following low-byte read completes the pair and removes the word.

Two status flags support interrupt-free polling. The empty flag shows the queue holds nothing. The watermark flag shows occupancy has reached one of two selectable byte levels. A sticky overflow bit records any word that was dropped for lack of room. With queue mode off, the queue is flushed and both flags stay low.

Top module: `spi_rx_queue`

## Requirements
- R1: With queue mode on, `rx_empty` is 1 exactly when the queue holds zero bytes. It reflects a push or pop from the clock edge that samples that push or pop.
- R2: In 8-bit mode (`wide`=0), a push stores `rx_data[7:0]` as one byte. While `rd_lo` is high, `rd_data` combinationally shows the oldest byte, and that byte is removed at the clock edge.
- R3: In 16-bit mode (`wide`=1), a push stores `rx_data[15:8]` as the high byte and `rx_data[7:0]` as the low byte of one entry. `rd_hi` shows the oldest high byte and removes nothing. A later `rd_lo` shows its low byte and removes the entry. An `rd_lo` with no `rd_hi` since the last removal shows the low byte and removes nothing.
- R4: With `thr_sel`=0 and queue mode on, `near_full` is 1 exactly when six or more bytes are held (three 16-bit words or six 8-bit bytes).
- R5: With `thr_sel`=1 and queue mode on, `near_full` is 1 exactly when four or more bytes are held (two 16-bit words or four 8-bit bytes).
- R6: The queue holds eight bytes. A push is accepted only if it fits, judged on the occupancy before any pop in the same cycle. A push that does not fit is dropped and sets `overflow`, which stays 1 until reset.
- R7: With `fifo_en`=0, `rx_empty` and `near_full` are 0, pushes are ignored, and every clock edge flushes the queue. Re-enabling shows an empty queue. `overflow` is not cleared.
- R8: A read strobe on an empty queue, or one that finds fewer bytes than one entry, has no effect and returns `rd_data`=0. When `rd_hi` and `rd_lo` are high together, only `rd_hi` takes effect.
- R9: Synchronous reset empties the queue and clears `overflow`. After reset with queue mode on, `rx_empty`=1 and `near_full`=0.
- R10: In 8-bit mode, `rd_hi` returns `rd_data`=0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_en | input | 1 | Queue mode enable |
| wide | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| thr_sel | input | 1 | Watermark select: 0 = six bytes, 1 = four bytes |
| rx_valid | input | 1 | One-cycle pulse: a received word is on `rx_data` |
| rx_data | input | 16 | Received word (low byte only in 8-bit mode) |
| rd_hi | input | 1 | Read strobe of the high data register |
| rd_lo | input | 1 | Read strobe of the low data register |
| rd_data | output | 8 | Byte returned for the active read strobe |
| rx_empty | output | 1 | Queue holds no data (queue mode only) |
| near_full | output | 1 | Occupancy at or above the selected watermark |
| overflow | output | 1 | Sticky: a received word was dropped |

## Verification
`rd_data` is combinational, so the bench drives a strobe away from the clock edge and compares the byte in that same cycle, before the edge. Pushes, pops and the effect of the enable pass through one register stage. `rx_empty`, `near_full` and `overflow` are therefore due just after the edge that samples the stimulus, and the bench checks them a short delay after that edge. A reference queue model is updated at each edge from the values the inputs held before it, so every comparison lines up with the cycle in which the design's registers change.

// File: rtl/spi_rxq_pkg.sv
package spi_rxq_pkg;

    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 2;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;

    // Width of one queue entry
    typedef enum logic {
        WIDTH_8  = 1'b0,
        WIDTH_16 = 1'b1
    } width_e;

    // Which data register the bus is reading this cycle
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_HI   = 2'd1,
        SEL_LO   = 2'd2
    } rd_sel_e;

    // Decoded read request handed to the control path
    typedef struct packed {
        rd_sel_e sel;
        logic    pop;
        logic    mark_hi;
        logic    clear_hi;
    } rd_dec_t;

    // Entry write request handed to the storage
    typedef struct packed {
        logic   en;
        width_e width;
        word_t  data;
    } wr_req_t;

    // Bytes that one entry occupies
    function automatic int unsigned entry_bytes(width_e w);
        return (w == WIDTH_16) ? WORD_BYTES : 1;
    endfunction

    // Watermark level in bytes for a select value
    function automatic int unsigned watermark_bytes(logic sel, int unsigned lvl0, int unsigned lvl1);
        return sel ? lvl1 : lvl0;
    endfunction

endpackage

// File: rtl/rxq_rd_decode.sv
module rxq_rd_decode
    import spi_rxq_pkg::*;
(
    input  width_e  width,
    input  logic    rd_hi,
    input  logic    rd_lo,
    input  logic    has_entry,
    input  logic    hi_seen,
    output rd_dec_t dec
);

    logic hi_act;
    logic lo_act;

    // A high-register strobe masks a simultaneous low-register strobe
    assign hi_act = rd_hi;
    assign lo_act = rd_lo & ~rd_hi;

    always_comb begin
        dec = '{sel: SEL_NONE, pop: 1'b0, mark_hi: 1'b0, clear_hi: 1'b0};
        if (has_entry) begin
            if (hi_act) begin
                dec.sel = SEL_HI;
            end else if (lo_act) begin
                dec.sel = SEL_LO;
            end
        end
        if (width == WIDTH_16) begin
            dec.pop     = lo_act & has_entry & hi_seen;
            dec.mark_hi = hi_act & has_entry;
        end else begin
            dec.pop     = lo_act & has_entry;
            dec.mark_hi = 1'b0;
        end
        dec.clear_hi = dec.pop | (width != WIDTH_16);
    end

endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import spi_rxq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  wr_req_t          wr,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [PTR_W-1:0] rd_ptr,
    output byte_t            head_b0,
    output byte_t            head_b1
);

    byte_t            slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr_nx;
    logic [PTR_W-1:0] rd_ptr_nx;
    byte_t            hi_byte;
    byte_t            lo_byte;

    assign wr_ptr_nx = wr_ptr + PTR_W'(1);
    assign rd_ptr_nx = rd_ptr + PTR_W'(1);
    assign hi_byte   = wr.data[WORD_W-1:BYTE_W];
    assign lo_byte   = wr.data[BYTE_W-1:0];

    // One register per byte slot; a 16-bit entry fills two neighbouring slots
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        byte_t slot_q;
        logic  hit_first;
        logic  hit_second;

        assign hit_first  = (wr_ptr == PTR_W'(i));
        assign hit_second = (wr.width == WIDTH_16) && (wr_ptr_nx == PTR_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q <= '0;
            end else if (wr.en) begin
                if (hit_first) begin
                    slot_q <= (wr.width == WIDTH_16) ? hi_byte : lo_byte;
                end else if (hit_second) begin
                    slot_q <= lo_byte;
                end
            end
        end

        assign slots[i] = slot_q;
    end

    assign head_b0 = slots[rd_ptr];
    assign head_b1 = slots[rd_ptr_nx];

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import spi_rxq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fifo_en,
    input  width_e           width,
    input  logic             rx_valid,
    input  word_t            rx_data,
    input  rd_dec_t          dec,
    output wr_req_t          wr,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [CNT_W-1:0] count,
    output logic             has_entry,
    output logic             hi_seen,
    output logic             overflow
);

    localparam int SUM_W = CNT_W + 1;

    logic [CNT_W-1:0] unit;
    logic             fits;
    logic             accept;
    logic             drop;
    logic [CNT_W-1:0] add_n;
    logic [CNT_W-1:0] sub_n;

    assign unit      = CNT_W'(entry_bytes(width));
    assign has_entry = (count >= unit);

    // Room is judged on the occupancy held before any pop in this cycle
    assign fits   = (SUM_W'(count) + SUM_W'(unit)) <= SUM_W'(DEPTH);
    assign accept = fifo_en & rx_valid & fits;
    assign drop   = fifo_en & rx_valid & ~fits;
    assign add_n  = accept  ? unit : '0;
    assign sub_n  = dec.pop ? unit : '0;

    assign wr = '{en: accept, width: width, data: rx_data};

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            hi_seen  <= 1'b0;
            overflow <= 1'b0;
        end else if (!fifo_en) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            hi_seen <= 1'b0;
        end else begin
            wr_ptr <= wr_ptr + PTR_W'(add_n);
            rd_ptr <= rd_ptr + PTR_W'(sub_n);
            count  <= count + add_n - sub_n;
            if (dec.clear_hi) begin
                hi_seen <= 1'b0;
            end else if (dec.mark_hi) begin
                hi_seen <= 1'b1;
            end
            if (drop) begin
                overflow <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
    import spi_rxq_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int LVL0_BYTES = 6,
    parameter int LVL1_BYTES = 4,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic             fifo_en,
    input  logic             thr_sel,
    input  logic [CNT_W-1:0] count,
    output logic             rx_empty,
    output logic             near_full
);

    logic [CNT_W-1:0] level;

    assign level     = CNT_W'(watermark_bytes(thr_sel, LVL0_BYTES, LVL1_BYTES));
    assign rx_empty  = fifo_en & (count == '0);
    assign near_full = fifo_en & (count >= level);

endmodule

// File: rtl/spi_rx_queue.sv
module spi_rx_queue
    import spi_rxq_pkg::*;
#(
    parameter int DEPTH_BYTES = 8,
    parameter int LVL0_BYTES  = 6,
    parameter int LVL1_BYTES  = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        fifo_en,
    input  logic        wide,
    input  logic        thr_sel,
    input  logic        rx_valid,
    input  logic [15:0] rx_data,
    input  logic        rd_hi,
    input  logic        rd_lo,
    output logic [7:0]  rd_data,
    output logic        rx_empty,
    output logic        near_full,
    output logic        overflow
);

    localparam int PTR_W = $clog2(DEPTH_BYTES);
    localparam int CNT_W = $clog2(DEPTH_BYTES + 1);

    width_e           width;
    rd_dec_t          dec;
    wr_req_t          wr;
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             has_entry;
    logic             hi_seen;
    byte_t            head_b0;
    byte_t            head_b1;

    assign width = wide ? WIDTH_16 : WIDTH_8;

    rxq_rd_decode u_dec (
        .width     (width),
        .rd_hi     (rd_hi),
        .rd_lo     (rd_lo),
        .has_entry (has_entry),
        .hi_seen   (hi_seen),
        .dec       (dec)
    );

    rxq_ctrl #(.DEPTH(DEPTH_BYTES)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .fifo_en   (fifo_en),
        .width     (width),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .dec       (dec),
        .wr        (wr),
        .wr_ptr    (wr_ptr),
        .rd_ptr    (rd_ptr),
        .count     (count),
        .has_entry (has_entry),
        .hi_seen   (hi_seen),
        .overflow  (overflow)
    );

    rxq_store #(.DEPTH(DEPTH_BYTES)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .head_b0 (head_b0),
        .head_b1 (head_b1)
    );

    rxq_flags #(
        .DEPTH      (DEPTH_BYTES),
        .LVL0_BYTES (LVL0_BYTES),
        .LVL1_BYTES (LVL1_BYTES)
    ) u_flags (
        .fifo_en   (fifo_en),
        .thr_sel   (thr_sel),
        .count     (count),
        .rx_empty  (rx_empty),
        .near_full (near_full)
    );

    // Byte presented to the bus for the active strobe
    always_comb begin
        unique case (dec.sel)
            SEL_HI:  rd_data = (width == WIDTH_16) ? head_b0 : '0;
            SEL_LO:  rd_data = (width == WIDTH_16) ? head_b1 : head_b0;
            default: rd_data = '0;
        endcase
    end

endmodule

// File: rtl/spi_rx_queue_checker.sv
module spi_rx_queue_checker (
    input logic clk,
    input logic rst,
    input logic fifo_en,
    input logic rx_valid,
    input logic rd_hi,
    input logic rd_lo,
    input logic rx_empty,
    input logic near_full,
    input logic overflow
);

    assert_off_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !fifo_en |-> (!rx_empty && !near_full));

    assert_push_fills_R1: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && rx_valid) |=> (!fifo_en || !rx_empty));

    assert_empty_read_R8: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && rx_empty && !rx_valid) |=> (!fifo_en || rx_empty));

    assert_no_lo_no_pop_R8: assert property (@(posedge clk) disable iff (rst)
        (fifo_en && !rx_empty && (!rd_lo || rd_hi)) |=> (!fifo_en || !rx_empty));

    assert_mark_implies_data_R4: assert property (@(posedge clk) disable iff (rst)
        near_full |-> !rx_empty);

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    assert_ovf_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow) |-> $past(fifo_en && rx_valid && near_full));

endmodule

bind spi_rx_queue spi_rx_queue_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .fifo_en   (fifo_en),
    .rx_valid  (rx_valid),
    .rd_hi     (rd_hi),
    .rd_lo     (rd_lo),
    .rx_empty  (rx_empty),
    .near_full (near_full),
    .overflow  (overflow)
);

// File: tb/spi_rx_queue_bench.sv
module spi_rx_queue_bench;

    localparam int CAP = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fifo_en = 1'b0;
    logic        wide = 1'b0;
    logic        thr_sel = 1'b0;
    logic        rx_valid = 1'b0;
    logic [15:0] rx_data = '0;
    logic        rd_hi = 1'b0;
    logic        rd_lo = 1'b0;
    logic [7:0]  rd_data;
    logic        rx_empty;
    logic        near_full;
    logic        overflow;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [7:0] mq [CAP];
    int         mcnt = 0;
    bit         mhi  = 1'b0;
    bit         movf = 1'b0;

    always #10 clk = ~clk;

    spi_rx_queue u_spi_rx_queue (
        .clk       (clk),
        .rst       (rst),
        .fifo_en   (fifo_en),
        .wide      (wide),
        .thr_sel   (thr_sel),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rd_hi     (rd_hi),
        .rd_lo     (rd_lo),
        .rd_data   (rd_data),
        .rx_empty  (rx_empty),
        .near_full (near_full),
        .overflow  (overflow)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int unit_of();
        return wide ? 2 : 1;
    endfunction

    function automatic logic [7:0] exp_rd(input bit hi, input bit lo);
        if (mcnt < unit_of()) return 8'h00;
        if (hi) return wide ? mq[0] : 8'h00;
        if (lo) return wide ? mq[1] : mq[0];
        return 8'h00;
    endfunction

    function automatic bit exp_empty();
        return fifo_en && (mcnt == 0);
    endfunction

    function automatic bit exp_near();
        return fifo_en && (mcnt >= (thr_sel ? 4 : 6));
    endfunction

    // Advance the model by one clock edge, from pre-edge inputs
    task automatic model_edge(input bit v, input logic [15:0] d, input bit hi, input bit lo);
        int  u;
        bit  pop;
        bit  acc;
        u = unit_of();
        if (!fifo_en) begin
            mcnt = 0;
            mhi  = 1'b0;
            return;
        end
        pop = lo && !hi && (mcnt >= u) && (!wide || mhi);
        acc = v && (mcnt + u <= CAP);
        if (v && !acc) movf = 1'b1;
        if (pop || !wide) mhi = 1'b0;
        else if (hi && mcnt >= u) mhi = 1'b1;
        if (pop) begin
            for (int i = 0; i < CAP - u; i++) mq[i] = mq[i + u];
            mcnt -= u;
        end
        if (acc) begin
            if (wide) begin
                mq[mcnt]     = d[15:8];
                mq[mcnt + 1] = d[7:0];
            end else begin
                mq[mcnt] = d[7:0];
            end
            mcnt += u;
        end
    endtask

    function automatic string flag_tag(input bit is_near);
        if (!fifo_en) return "R7";
        if (!is_near) return "R1";
        return thr_sel ? "R5" : "R4";
    endfunction

    // One bus cycle: drive after the falling edge, check data before the rising edge, flags after it
    task automatic step(input bit v, input logic [15:0] d, input bit hi, input bit lo);
        logic [7:0] er;
        string      tag;
        rx_valid = v;
        rx_data  = d;
        rd_hi    = hi;
        rd_lo    = lo;
        #1;
        er = exp_rd(hi, lo);
        if (hi && !wide)              tag = "R10";
        else if (mcnt < unit_of())    tag = "R8";
        else                          tag = wide ? "R3" : "R2";
        if (hi || lo) check(rd_data == er, tag, rd_data, er);
        @(posedge clk);
        model_edge(v, d, hi, lo);
        #1;
        check(rx_empty == exp_empty(), flag_tag(1'b0), rx_empty, exp_empty());
        check(near_full == exp_near(), flag_tag(1'b1), near_full, exp_near());
        check(overflow == movf, "R6", overflow, movf);
        @(negedge clk);
        rx_valid = 1'b0;
        rd_hi    = 1'b0;
        rd_lo    = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst  = 1'b0;
        mcnt = 0;
        mhi  = 1'b0;
        movf = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5A17));
        fifo_en = 1'b1;
        do_reset();

        // R9: state after reset
        check(rx_empty == 1'b1, "R9", rx_empty, 1);
        check(near_full == 1'b0, "R9", near_full, 0);
        check(overflow == 1'b0, "R9", overflow, 0);

        // R2 / R4 / R6: 8-bit fill past capacity, then drain
        wide = 1'b0; thr_sel = 1'b0;
        for (int i = 0; i < 9; i++) step(1'b1, 16'hA000 | 16'(8'h10 + i), 1'b0, 1'b0);
        check(overflow == 1'b1, "R6", overflow, 1);
        step(1'b0, '0, 1'b1, 1'b0);                 // R10: high read in 8-bit mode
        for (int i = 0; i < 8; i++) step(1'b0, '0, 1'b0, 1'b1);
        step(1'b0, '0, 1'b0, 1'b1);                 // R8: read on empty
        check(rx_empty == 1'b1, "R8", rx_empty, 1);

        // R5: lower watermark in 8-bit mode
        thr_sel = 1'b1;
        for (int i = 0; i < 5; i++) step(1'b1, 16'(8'h40 + i), 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) step(1'b0, '0, 1'b0, 1'b1);

        // R3: 16-bit entries, unpaired low read, pair read, both strobes
        wide = 1'b1; thr_sel = 1'b0;
        for (int i = 0; i < 5; i++) step(1'b1, 16'hC0D0 + 16'(i * 16'h0101), 1'b0, 1'b0);
        step(1'b0, '0, 1'b0, 1'b1);                 // no pop without high read
        step(1'b0, '0, 1'b1, 1'b1);                 // both strobes: high only
        step(1'b0, '0, 1'b0, 1'b1);                 // completes the pair
        step(1'b1, 16'hBEEF, 1'b0, 1'b0);
        thr_sel = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step(1'b0, '0, 1'b1, 1'b0);
            step(1'b0, '0, 1'b0, 1'b1);
        end

        // R7: disable with data held, push while off, re-enable
        step(1'b1, 16'h1234, 1'b0, 1'b0);
        step(1'b1, 16'h5678, 1'b0, 1'b0);
        fifo_en = 1'b0;
        step(1'b1, 16'h9ABC, 1'b0, 1'b0);
        step(1'b0, '0, 1'b0, 1'b0);
        fifo_en = 1'b1;
        step(1'b0, '0, 1'b0, 1'b0);
        check(rx_empty == 1'b1, "R7", rx_empty, 1);
        check(overflow == 1'b1, "R7", overflow, 1);

        // R9: reset clears the sticky overflow
        do_reset();
        check(overflow == 1'b0, "R9", overflow, 0);

        // Random traffic in both widths
        for (int m = 0; m < 2; m++) begin
            fifo_en = 1'b0;
            step(1'b0, '0, 1'b0, 1'b0);
            fifo_en = 1'b1;
            wide = m[0];
            for (int k = 0; k < 600; k++) begin
                bit v;
                bit hi;
                bit lo;
                thr_sel = ($urandom % 8) == 0 ? ~thr_sel : thr_sel;
                v  = ($urandom % 3) != 0;
                hi = ($urandom % 3) == 0;
                lo = ($urandom % 2) == 0;
                step(v, 16'($urandom), hi, lo);
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule